// File: doc/BRIEF.md
# Lane-Partitioned Vector Multiply Unit

This block multiplies two packed vector operands lane by lane. One datapath serves lanes of 8, 16, 32 and 64 bits and four multiply flavours:

- the low half of the product;
- the high half of the signed product;
- the high half of the unsigned product;
- a carry-less byte product.

A small decoder checks a 32-bit instruction word against a fixed opcode pattern. It takes the lane size, the flavour and the register numbers from that word. Encodings that are not legal are flagged as undefined.

Operands and the instruction enter together through a valid/ready handshake. The result appears two cycles later, together with the undefined flag and the destination register number. An active-length input gives how many low-order bytes of the vector carry results. Every byte at or above that length is written as zero. The vector width is a parameter (`VEC_BYTES`, a multiple of 8). Lanes are packed little-endian, so lane 0 occupies the lowest bits.

Top module: `vmul_lane_unit`

## Requirements
- R1: An instruction is legal only when bits [31:24] are 8'h04, bit 21 is 1 and bits [15:12] are 4'b0110. Any other word raises `undefFlag` and gives an all-zero result.
- R2: The lane size comes from bits [23:22] (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes). `srcFirst` shows bits [9:5] and `srcSecond` shows bits [20:16] combinationally. `dstIdx` returns bits [4:0] alongside the result.
- R3: Selector bits [11:10] = 2'b00 give, in each lane of N bits, bits [N-1:0] of the product.
- R4: Selector 2'b10 gives bits [2N-1:N] of the product of the sign-extended lanes.
- R5: Selector 2'b11 gives bits [2N-1:N] of the product of the zero-extended lanes, exact up to 64-bit lanes.
- R6: Selector 2'b01 with size code 0 gives, per byte, the low 8 bits of the carry-less (XOR-accumulated) product. With any other size code the instruction is undefined, and the result is zero.
- R7: Every result byte whose index is at or above `activeBytes` is zero.
- R8: A transfer accepted at clock edge k makes `outValid` high after edge k+2, with its result.
- R9: While `outValid` is high and `outReady` is low, `inReady` is low and the result, flag and destination hold steady.
- R10: During and just after reset, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and instruction are offered |
| inReady | output | 1 | Unit accepts an offer this cycle |
| instrWord | input | 32 | Instruction word to decode |
| opA | input | VEC_BYTES*8 | First packed operand |
| opB | input | VEC_BYTES*8 | Second packed operand |
| activeBytes | input | $clog2(VEC_BYTES+1) | Number of low-order bytes that carry results |
| srcFirst | output | 5 | First source register number from the instruction |
| srcSecond | output | 5 | Second source register number from the instruction |
| outValid | output | 1 | Result is presented |
| outReady | input | 1 | Consumer takes the result |
| result | output | VEC_BYTES*8 | Packed result |
| undefFlag | output | 1 | Instruction was not a legal encoding |
| dstIdx | output | 5 | Destination register number |

## Verification
Register numbers on the source outputs are due in the same cycle as the instruction word. The bench compares them before any clock edge. Result, flag and destination are due two edges after acceptance. Inputs are driven on the falling edge and withdrawn one cycle later. The bench confirms that `outValid` is still low after the first rising edge, and samples the outputs on the falling edge after the second. Under backpressure it samples again on later falling edges to confirm the outputs hold, then releases `outReady` and confirms `outValid` drops one edge later.

// File: rtl/vmul_pkg.sv
package vmul_pkg;

  typedef enum logic [1:0] {
    OP_LOW   = 2'b00,
    OP_POLY  = 2'b01,
    OP_SHIGH = 2'b10,
    OP_UHIGH = 2'b11
  } mulOp_e;

  typedef struct packed {
    logic capture;   // load stage-1 operand registers
    logic retire;    // load stage-2 result registers
  } pipeStrobe_t;

  typedef struct packed {
    logic [1:0] sizeCode;
    mulOp_e     op;
    logic [4:0] dst;
    logic       undef;
  } decInfo_t;

  function automatic logic [7:0] clmul8(input logic [7:0] x, input logic [7:0] y);
    logic [14:0] acc;
    acc = '0;
    for (int j = 0; j < 8; j++) begin
      if (y[j]) acc = acc ^ (15'(x) << j);
    end
    return acc[7:0];
  endfunction

endpackage

// File: rtl/vmul_ctrl.sv
module vmul_ctrl
  import vmul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output logic        inReady,
  input  logic        outReady,
  output logic        outValid,
  input  logic [31:0] instrWord,
  output decInfo_t    dec,
  output pipeStrobe_t strobe,
  output logic [4:0]  srcFirst,
  output logic [4:0]  srcSecond
);

  logic stage1Valid, stage2Valid, advance, patternOk;

  always_comb begin
    patternOk    = (instrWord[31:24] == 8'h04) && instrWord[21] && (instrWord[15:12] == 4'b0110);
    dec.sizeCode = instrWord[23:22];
    dec.op       = mulOp_e'(instrWord[11:10]);
    dec.dst      = instrWord[4:0];
    dec.undef    = !patternOk || ((instrWord[11:10] == OP_POLY) && (instrWord[23:22] != 2'b00));
    srcFirst     = instrWord[9:5];
    srcSecond    = instrWord[20:16];
  end

  assign advance        = !stage2Valid || outReady;
  assign inReady        = advance;
  assign strobe.capture = advance && inValid;
  assign strobe.retire  = advance && stage1Valid;
  assign outValid       = stage2Valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else if (advance) begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  assert_two_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> ##1 outValid);

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> !outValid);

endmodule

// File: rtl/vmul_datapath.sv
module vmul_datapath
  import vmul_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  localparam int VEC_BITS = VEC_BYTES * 8,
  localparam int LEN_W    = $clog2(VEC_BYTES + 1)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  pipeStrobe_t         strobe,
  input  decInfo_t            dec,
  input  logic [VEC_BITS-1:0] opA,
  input  logic [VEC_BITS-1:0] opB,
  input  logic [LEN_W-1:0]    activeBytes,
  output logic [VEC_BITS-1:0] result,
  output logic                undefFlag,
  output logic [4:0]          dstIdx
);

  logic [VEC_BITS-1:0] aQ, bQ;
  logic [1:0]          sizeQ;
  mulOp_e              opQ;
  logic [LEN_W-1:0]    activeQ;
  logic                undefQ;
  logic [4:0]          dstQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aQ <= '0; bQ <= '0; sizeQ <= '0; opQ <= OP_LOW;
      activeQ <= '0; undefQ <= 1'b0; dstQ <= '0;
    end else if (strobe.capture) begin
      aQ <= opA; bQ <= opB; sizeQ <= dec.sizeCode; opQ <= dec.op;
      activeQ <= activeBytes; undefQ <= dec.undef; dstQ <= dec.dst;
    end
  end

  logic                      signedHi;
  logic [3:0][VEC_BITS-1:0]  loBySize, hiBySize;
  logic [VEC_BITS-1:0]       polyVec, picked, masked;

  assign signedHi = (opQ == OP_SHIGH);

  for (genvar g = 0; g < 4; g++) begin : gSize
    localparam int W = 8 << g;
    localparam int LANES = VEC_BITS / W;
    for (genvar l = 0; l < LANES; l++) begin : gLane
      logic [W-1:0]   la, lb;
      logic [2*W-1:0] ea, eb, prod;
      assign la   = aQ[l*W +: W];
      assign lb   = bQ[l*W +: W];
      assign ea   = signedHi ? {{W{la[W-1]}}, la} : {{W{1'b0}}, la};
      assign eb   = signedHi ? {{W{lb[W-1]}}, lb} : {{W{1'b0}}, lb};
      assign prod = ea * eb;
      assign loBySize[g][l*W +: W] = prod[W-1:0];
      assign hiBySize[g][l*W +: W] = prod[2*W-1:W];
      if (g == 0) begin : gPoly
        assign polyVec[l*8 +: 8] = clmul8(la, lb);
      end
    end
  end

  always_comb begin
    unique case (opQ)
      OP_LOW:  picked = loBySize[sizeQ];
      OP_POLY: picked = polyVec;
      default: picked = hiBySize[sizeQ];
    endcase
    for (int i = 0; i < VEC_BYTES; i++) begin
      if (undefQ || (32'(i) >= 32'(activeQ))) masked[i*8 +: 8] = '0;
      else                                    masked[i*8 +: 8] = picked[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0; undefFlag <= 1'b0; dstIdx <= '0;
    end else if (strobe.retire) begin
      result <= masked; undefFlag <= undefQ; dstIdx <= dstQ;
    end
  end

  function automatic logic tailClear(input logic [VEC_BITS-1:0] r, input logic [LEN_W-1:0] n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < VEC_BYTES; i++)
      if ((32'(i) >= 32'(n)) && (r[i*8 +: 8] != 8'h00)) ok = 1'b0;
    return ok;
  endfunction

  assert_tail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.retire |=> tailClear(result, $past(activeQ)));

  assert_undef_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.retire && undefQ) |=> (undefFlag && (result == '0)));

endmodule

// File: rtl/vmul_lane_unit.sv
module vmul_lane_unit
  import vmul_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  localparam int VEC_BITS = VEC_BYTES * 8,
  localparam int LEN_W    = $clog2(VEC_BYTES + 1)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  output logic                inReady,
  input  logic [31:0]         instrWord,
  input  logic [VEC_BITS-1:0] opA,
  input  logic [VEC_BITS-1:0] opB,
  input  logic [LEN_W-1:0]    activeBytes,
  output logic [4:0]          srcFirst,
  output logic [4:0]          srcSecond,
  output logic                outValid,
  input  logic                outReady,
  output logic [VEC_BITS-1:0] result,
  output logic                undefFlag,
  output logic [4:0]          dstIdx
);

  decInfo_t    dec;
  pipeStrobe_t strobe;

  vmul_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .instrWord(instrWord),
    .dec(dec), .strobe(strobe), .srcFirst(srcFirst), .srcSecond(srcSecond)
  );

  vmul_datapath #(.VEC_BYTES(VEC_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dec(dec), .opA(opA), .opB(opB),
    .activeBytes(activeBytes), .result(result), .undefFlag(undefFlag), .dstIdx(dstIdx)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(result) && $stable(undefFlag) && $stable(dstIdx)));

endmodule

// File: tb/vmul_lane_unit_bench.sv
module vmul_lane_unit_bench;
  localparam int VB = 16;
  localparam int VW = VB * 8;
  localparam int LW = $clog2(VB + 1);

  logic clk = 1'b0, rst_n = 1'b0, inValid = 1'b0, outReady = 1'b1;
  logic inReady, outValid, undefFlag;
  logic [31:0] instrWord = '0;
  logic [VW-1:0] opA = '0, opB = '0, result;
  logic [LW-1:0] activeBytes = '0;
  logic [4:0] srcFirst, srcSecond, dstIdx;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vmul_lane_unit #(.VEC_BYTES(VB)) u_vmul_lane_unit (.*);

  function automatic logic [31:0] mkInstr(input logic [1:0] sz, input logic [1:0] op,
                                          input logic [4:0] m, input logic [4:0] n, input logic [4:0] d);
    return {8'h04, sz, 1'b1, m, 4'b0110, op, n, d};
  endfunction

  typedef struct packed {
    logic [31:0]   iw;
    logic [VW-1:0] a;
    logic [VW-1:0] b;
    logic [LW-1:0] act;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TABLE [NV] = '{
    '{mkInstr(2'd0, 2'b00, 5'd1, 5'd2, 5'd3),  128'h0102_0304_F0E0_D0C0_7F80_FF01_1122_3344, 128'h0506_0708_0F0E_0D0C_02FF_80FF_5566_7788, 5'd16},
    '{mkInstr(2'd1, 2'b10, 5'd4, 5'd5, 5'd6),  128'h8000_7FFF_FFFF_1234_8000_0001_C000_4000, 128'h8000_7FFF_0002_FEDC_7FFF_FFFF_C000_4000, 5'd16},
    '{mkInstr(2'd2, 2'b11, 5'd7, 5'd8, 5'd9),  128'hFFFF_FFFF_8000_0000_1234_5678_0000_0010, 128'hFFFF_FFFF_0000_0002_9ABC_DEF0_1000_0000, 5'd16},
    '{mkInstr(2'd3, 2'b11, 5'd10, 5'd11, 5'd12), {128{1'b1}}, {128{1'b1}}, 5'd16},
    '{mkInstr(2'd3, 2'b10, 5'd13, 5'd14, 5'd15), 128'h8000_0000_0000_0000_FFFF_FFFF_FFFF_FFFD, 128'h8000_0000_0000_0000_0123_4567_89AB_CDEF, 5'd16},
    '{mkInstr(2'd0, 2'b01, 5'd16, 5'd17, 5'd18), 128'hFF80_0102_5A3C_E7F0_0F11_8844_2233_AA55, 128'hFF03_8003_A5C3_1E0F_F022_1144_0102_55AA, 5'd16},
    '{mkInstr(2'd2, 2'b00, 5'd19, 5'd20, 5'd21), 128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'h0000_0003_0000_0005_FFFF_FFFF_0001_0001, 5'd8},
    '{mkInstr(2'd1, 2'b01, 5'd22, 5'd23, 5'd24), 128'h1234_5678_9ABC_DEF0_1234_5678_9ABC_DEF0, 128'h0F0F_F0F0_0F0F_F0F0_0F0F_F0F0_0F0F_F0F0, 5'd16},
    '{32'h0520_6000 | 32'h0000_001F,           128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 128'h0000_0002_0000_0002_0000_0002_0000_0002, 5'd16},
    '{mkInstr(2'd0, 2'b11, 5'd25, 5'd26, 5'd27), 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 5'd0}
  };

  // Reference: R1/R6 legality, R3/R4/R5/R6 arithmetic, R7 masking.
  task automatic refModel(input logic [31:0] iw, input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input int act, output logic [VW-1:0] r, output bit und);
    int w;
    logic [1:0] op;
    w  = 8 << iw[23:22];
    op = iw[11:10];
    r  = '0;
    und = !(iw[31:24] == 8'h04 && iw[21] && iw[15:12] == 4'b0110) || (op == 2'b01 && iw[23:22] != 2'b00);
    if (!und) begin
      for (int l = 0; l < VW / w; l++) begin
        logic [127:0] xa, xb, p;
        logic [15:0] pp;
        xa = '0; xb = '0; pp = '0;
        for (int k = 0; k < w; k++) begin xa[k] = a[l*w+k]; xb[k] = b[l*w+k]; end
        if (op == 2'b10)
          for (int k = w; k < 128; k++) begin xa[k] = xa[w-1]; xb[k] = xb[w-1]; end
        p = xa * xb;
        for (int j = 0; j < 8; j++) if (xb[j]) pp = pp ^ (xa[15:0] << j);
        for (int k = 0; k < w; k++)
          r[l*w+k] = (op == 2'b00) ? p[k] : (op == 2'b01) ? pp[k] : p[k+w];
      end
      for (int i = 0; i < VB; i++) if (i >= act) r[i*8 +: 8] = '0;
    end
  endtask

  function automatic string reqOf(input logic [31:0] iw);
    if (!(iw[31:24] == 8'h04 && iw[21] && iw[15:12] == 4'b0110)) return "R1";
    case (iw[11:10])
      2'b00:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic offer(input vec_t v);
    @(negedge clk);
    instrWord = v.iw; opA = v.a; opB = v.b; activeBytes = v.act; inValid = 1'b1;
  endtask

  logic [VW-1:0] expR, held;
  bit expU;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 outValid in reset", VW'(outValid), '0);
    check("R10 inReady in reset", VW'(inReady), VW'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 outValid after reset", VW'(outValid), '0);

    // Table walk: R3 R4 R5 R6 R7 R1, with R8 timing and R2 fields
    for (int t = 0; t < NV; t++) begin
      offer(TABLE[t]);
      #0.5;
      check("R2 srcFirst", VW'(srcFirst), VW'(TABLE[t].iw[9:5]));
      check("R2 srcSecond", VW'(srcSecond), VW'(TABLE[t].iw[20:16]));
      @(negedge clk);
      inValid = 1'b0;
      check("R8 not valid after one edge", VW'(outValid), '0);
      @(negedge clk);
      check("R8 valid after two edges", VW'(outValid), VW'(1));
      refModel(TABLE[t].iw, TABLE[t].a, TABLE[t].b, int'(TABLE[t].act), expR, expU);
      check(reqOf(TABLE[t].iw), result, expR);
      check("R1/R6 undefFlag", VW'(undefFlag), VW'(expU));
      check("R2 dstIdx", VW'(dstIdx), VW'(TABLE[t].iw[4:0]));
      if (TABLE[t].act < VB) begin
        logic [VW-1:0] tail;
        tail = result;
        for (int i = 0; i < int'(TABLE[t].act); i++) tail[i*8 +: 8] = '0;
        check("R7 tail bytes", tail, '0);
      end
      @(negedge clk);
      check("R8 single result", VW'(outValid), '0);
    end

    // R9: backpressure holds outputs and blocks input
    outReady = 1'b0;
    offer(TABLE[1]);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    refModel(TABLE[1].iw, TABLE[1].a, TABLE[1].b, 16, expR, expU);
    check("R9 valid under stall", VW'(outValid), VW'(1));
    check("R9 inReady low", VW'(inReady), '0);
    held = result;
    check("R9 result", held, expR);
    repeat (3) @(negedge clk);
    check("R9 still valid", VW'(outValid), VW'(1));
    check("R9 result held", result, held);
    check("R9 dst held", VW'(dstIdx), VW'(TABLE[1].iw[4:0]));
    outReady = 1'b1;
    #0.5;
    check("R9 inReady on release", VW'(inReady), VW'(1));
    @(negedge clk);
    check("R9 drained", VW'(outValid), '0);

    // R10: mid-run reset clears outstanding result
    offer(TABLE[0]);
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears valid", VW'(outValid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 stays idle", VW'(outValid), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule